// File: doc/BRIEF.md
# Immediate and Shift Execute Unit

This unit is the combinational execute stage of a 32-bit RISC core for the instructions that take a constant. These are load-upper-immediate, AND and OR with an immediate, add-immediate, and left or right logical shifts by a fixed amount. Decode supplies an operation select, both source register values, the 16-bit immediate, the 5-bit shift amount and the two candidate destination indices. The unit returns the result and the index of the register to write, all within the same cycle.

Each opcode extends its immediate in its own way. The logic operations pad the immediate with zeros. The add replicates the immediate's sign bit. The upper load places the immediate in the top half. Because the OR pads with zeros, an upper load followed by an OR into the same register builds any 32-bit constant. Shifts take their operand from the rt value, shift it by the shamt field and write the rd register; the rs value plays no part in them.

Top module: `imm_shift_exec`

## Requirements
- R1: With opSel = 0 (upper load), result equals {imm, 16'h0000}, and dstIdx equals rtIdx.
- R2: With opSel = 1 (AND immediate), result equals rsVal AND {16'h0000, imm}, so the upper 16 result bits are always zero.
- R3: With opSel = 2 (OR immediate), result equals rsVal OR {16'h0000, imm}. An upper load of H followed by an OR of L, with the upper-load result fed back as rsVal, yields {H, L} for any H and L, including L with bit 15 set.
- R4: With opSel = 3 (add immediate), result equals rsVal plus the sign-extended imm, modulo 2^32, with no overflow indication.
- R5: With opSel = 4 (left shift), result equals rtVal shifted left by shamt, with the vacated low bits filled with zeros.
- R6: With opSel = 5 (right shift), result equals rtVal shifted right by shamt, with the vacated high bits filled with zeros (bit 31 is not replicated).
- R7: dstIdx equals rtIdx for opSel 0 to 3 and rdIdx for opSel 4 and 5.
- R8: opSel 6 and 7 are illegal: result is 0, dstIdx is 0 and illegalOp is 1. For opSel 0 to 5, illegalOp is 0.
- R9: For shifts the rsVal input has no effect on the result. For opSel 0 to 3 the rtVal input has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opSel | input | 3 | Decoded operation select (encoding in R1 to R8) |
| rsVal | input | 32 | Value of the rs source register |
| rtVal | input | 32 | Value of the rt source register |
| imm | input | 16 | Immediate field |
| shamt | input | 5 | Shift-amount field |
| rtIdx | input | 5 | rt register index |
| rdIdx | input | 5 | rd register index |
| result | output | 32 | Operation result |
| dstIdx | output | 5 | Index of the register to write |
| illegalOp | output | 1 | High for an unrecognised operation select |

## Verification
Whenever its inputs change, the checker confirms each operation's result against that operation's rule. It checks zero upper halves for the AND, the immediate-topped and zero-bottomed upper load, the wrapped sum for the add, and zero-filled vacated bits for both shifts. It also checks the choice of destination index and the clean zero output of an illegal select. Some behaviours appear only in the bench's scenarios. These are the two-instruction constant build through a fed-back result, the way the rs and rt values have no effect when they are not operands, and the exact shifted values at the boundary amounts of 0 and 31.

// File: rtl/imm_shift_pkg.sv
package imm_shift_pkg;

  localparam int OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_LUI  = 3'd0,
    OP_ANDI = 3'd1,
    OP_ORI  = 3'd2,
    OP_ADDI = 3'd3,
    OP_SLL  = 3'd4,
    OP_SRL  = 3'd5
  } exeOp_e;

  typedef enum logic [1:0] {
    EXT_ZERO  = 2'd0,
    EXT_SIGN  = 2'd1,
    EXT_UPPER = 2'd2
  } extMode_e;

  typedef enum logic [2:0] {
    UNIT_AND   = 3'd0,
    UNIT_OR    = 3'd1,
    UNIT_ADD   = 3'd2,
    UNIT_SHIFT = 3'd3,
    UNIT_PASS  = 3'd4
  } unitSel_e;

  typedef struct packed {
    extMode_e extMode;
    unitSel_e unitSel;
    logic     shiftRight;
    logic     useRdDst;
    logic     illegal;
  } exeStrobes_t;

endpackage

// File: rtl/imm_shift_ctrl.sv
module imm_shift_ctrl
  import imm_shift_pkg::*;
(
  input  logic [OP_W-1:0] opSel,
  output exeStrobes_t     strobes
);

  always_comb begin
    strobes            = '0;
    strobes.extMode    = EXT_ZERO;
    strobes.unitSel    = UNIT_PASS;
    strobes.shiftRight = 1'b0;
    strobes.useRdDst   = 1'b0;
    strobes.illegal    = 1'b0;
    case (opSel)
      OP_LUI: begin
        strobes.extMode = EXT_UPPER;
        strobes.unitSel = UNIT_PASS;
      end
      OP_ANDI: begin
        strobes.extMode = EXT_ZERO;
        strobes.unitSel = UNIT_AND;
      end
      OP_ORI: begin
        strobes.extMode = EXT_ZERO;
        strobes.unitSel = UNIT_OR;
      end
      OP_ADDI: begin
        strobes.extMode = EXT_SIGN;
        strobes.unitSel = UNIT_ADD;
      end
      OP_SLL: begin
        strobes.unitSel  = UNIT_SHIFT;
        strobes.useRdDst = 1'b1;
      end
      OP_SRL: begin
        strobes.unitSel    = UNIT_SHIFT;
        strobes.shiftRight = 1'b1;
        strobes.useRdDst   = 1'b1;
      end
      default: begin
        strobes.illegal = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/imm_shift_barrel.sv
module imm_shift_barrel #(
  parameter int DATA_W      = 32,
  parameter int SHAMT_W     = 5,
  parameter bit SHIFT_RIGHT = 1'b0
) (
  input  logic [DATA_W-1:0]  din,
  input  logic [SHAMT_W-1:0] amt,
  output logic [DATA_W-1:0]  dout
);

  logic [DATA_W-1:0] stage [0:SHAMT_W];

  assign stage[0] = din;

  for (genvar s = 0; s < SHAMT_W; s++) begin : g_stage
    localparam int STEP = 1 << s;
    if (SHIFT_RIGHT) begin : g_right
      assign stage[s+1] = amt[s] ? (stage[s] >> STEP) : stage[s];
    end else begin : g_left
      assign stage[s+1] = amt[s] ? (stage[s] << STEP) : stage[s];
    end
  end

  assign dout = stage[SHAMT_W];

endmodule

// File: rtl/imm_shift_dp.sv
module imm_shift_dp
  import imm_shift_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int IMM_W   = 16,
  parameter int SHAMT_W = 5,
  parameter int IDX_W   = 5
) (
  input  exeStrobes_t        strobes,
  input  logic [DATA_W-1:0]  rsVal,
  input  logic [DATA_W-1:0]  rtVal,
  input  logic [IMM_W-1:0]   imm,
  input  logic [SHAMT_W-1:0] shamt,
  input  logic [IDX_W-1:0]   rtIdx,
  input  logic [IDX_W-1:0]   rdIdx,
  output logic [DATA_W-1:0]  result,
  output logic [IDX_W-1:0]   dstIdx
);

  localparam int PAD_W = DATA_W - IMM_W;

  logic [DATA_W-1:0] extImm;
  logic [DATA_W-1:0] leftOut;
  logic [DATA_W-1:0] rightOut;
  logic [DATA_W-1:0] unitOut;

  always_comb begin
    case (strobes.extMode)
      EXT_SIGN:  extImm = {{PAD_W{imm[IMM_W-1]}}, imm};
      EXT_UPPER: extImm = {imm, {PAD_W{1'b0}}};
      default:   extImm = {{PAD_W{1'b0}}, imm};
    endcase
  end

  imm_shift_barrel #(
    .DATA_W(DATA_W), .SHAMT_W(SHAMT_W), .SHIFT_RIGHT(1'b0)
  ) u_left (
    .din(rtVal), .amt(shamt), .dout(leftOut)
  );

  imm_shift_barrel #(
    .DATA_W(DATA_W), .SHAMT_W(SHAMT_W), .SHIFT_RIGHT(1'b1)
  ) u_right (
    .din(rtVal), .amt(shamt), .dout(rightOut)
  );

  always_comb begin
    case (strobes.unitSel)
      UNIT_AND:   unitOut = rsVal & extImm;
      UNIT_OR:    unitOut = rsVal | extImm;
      UNIT_ADD:   unitOut = rsVal + extImm;
      UNIT_SHIFT: unitOut = strobes.shiftRight ? rightOut : leftOut;
      default:    unitOut = extImm;
    endcase
  end

  always_comb begin
    if (strobes.illegal) begin
      result = '0;
      dstIdx = '0;
    end else begin
      result = unitOut;
      dstIdx = strobes.useRdDst ? rdIdx : rtIdx;
    end
  end

endmodule

// File: rtl/imm_shift_exec.sv
module imm_shift_exec
  import imm_shift_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int IMM_W   = 16,
  parameter int SHAMT_W = 5,
  parameter int IDX_W   = 5
) (
  input  logic [OP_W-1:0]    opSel,
  input  logic [DATA_W-1:0]  rsVal,
  input  logic [DATA_W-1:0]  rtVal,
  input  logic [IMM_W-1:0]   imm,
  input  logic [SHAMT_W-1:0] shamt,
  input  logic [IDX_W-1:0]   rtIdx,
  input  logic [IDX_W-1:0]   rdIdx,
  output logic [DATA_W-1:0]  result,
  output logic [IDX_W-1:0]   dstIdx,
  output logic               illegalOp
);

  exeStrobes_t strobes;

  imm_shift_ctrl u_ctrl (
    .opSel  (opSel),
    .strobes(strobes)
  );

  imm_shift_dp #(
    .DATA_W(DATA_W), .IMM_W(IMM_W), .SHAMT_W(SHAMT_W), .IDX_W(IDX_W)
  ) u_dp (
    .strobes(strobes),
    .rsVal  (rsVal),
    .rtVal  (rtVal),
    .imm    (imm),
    .shamt  (shamt),
    .rtIdx  (rtIdx),
    .rdIdx  (rdIdx),
    .result (result),
    .dstIdx (dstIdx)
  );

  assign illegalOp = strobes.illegal;

endmodule

// File: rtl/imm_shift_exec_chk.sv
module imm_shift_exec_chk
  import imm_shift_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int IMM_W   = 16,
  parameter int SHAMT_W = 5,
  parameter int IDX_W   = 5
) (
  input logic [OP_W-1:0]    opSel,
  input logic [DATA_W-1:0]  rsVal,
  input logic [DATA_W-1:0]  rtVal,
  input logic [IMM_W-1:0]   imm,
  input logic [SHAMT_W-1:0] shamt,
  input logic [IDX_W-1:0]   rtIdx,
  input logic [IDX_W-1:0]   rdIdx,
  input logic [DATA_W-1:0]  result,
  input logic [IDX_W-1:0]   dstIdx,
  input logic               illegalOp
);

  localparam int PAD_W = DATA_W - IMM_W;

  logic [DATA_W-1:0] one;
  logic [DATA_W-1:0] lowMask;
  logic [DATA_W-1:0] highMask;
  logic [DATA_W-1:0] wantSum;

  assign one      = {{(DATA_W-1){1'b0}}, 1'b1};
  assign lowMask  = (one << shamt) - one;
  assign highMask = ~({DATA_W{1'b1}} >> shamt);
  assign wantSum  = rsVal + {{PAD_W{imm[IMM_W-1]}}, imm};

  always_comb begin
    if (opSel == OP_LUI) begin
      p_lui_shape_r1: assert (result[PAD_W-1:0] == '0 && result[DATA_W-1:PAD_W] == imm)
        else $error("upper load shape wrong");
    end
    if (opSel == OP_ANDI) begin
      p_andi_top_zero_r2: assert (result[DATA_W-1:IMM_W] == '0 && (result & ~rsVal) == '0)
        else $error("AND immediate touched upper half");
    end
    if (opSel == OP_ORI) begin
      p_ori_keep_top_r3: assert (result[DATA_W-1:IMM_W] == rsVal[DATA_W-1:IMM_W])
        else $error("OR immediate changed upper half");
    end
    if (opSel == OP_ADDI) begin
      p_addi_wrap_r4: assert (result == wantSum)
        else $error("add immediate sum wrong");
    end
    if (opSel == OP_SLL) begin
      p_sll_zero_fill_r5: assert ((result & lowMask) == '0)
        else $error("left shift fill not zero");
    end
    if (opSel == OP_SRL) begin
      p_srl_zero_fill_r6: assert ((result & highMask) == '0)
        else $error("right shift fill not zero");
    end
    if (opSel == OP_SLL || opSel == OP_SRL) begin
      p_dst_rd_r7: assert (dstIdx == rdIdx) else $error("shift destination wrong");
    end else if (!illegalOp) begin
      p_dst_rt_r7: assert (dstIdx == rtIdx) else $error("immediate destination wrong");
    end
    if (opSel > OP_SRL) begin
      p_illegal_clean_r8: assert (illegalOp && result == '0 && dstIdx == '0)
        else $error("illegal select not flagged cleanly");
    end else begin
      p_legal_no_flag_r8: assert (!illegalOp) else $error("legal select flagged");
    end
  end

endmodule

bind imm_shift_exec imm_shift_exec_chk #(
  .DATA_W(DATA_W), .IMM_W(IMM_W), .SHAMT_W(SHAMT_W), .IDX_W(IDX_W)
) u_chk (
  .opSel(opSel), .rsVal(rsVal), .rtVal(rtVal), .imm(imm), .shamt(shamt),
  .rtIdx(rtIdx), .rdIdx(rdIdx), .result(result), .dstIdx(dstIdx),
  .illegalOp(illegalOp)
);

// File: tb/test_imm_shift_exec.sv
`timescale 1ns/1ps
module test_imm_shift_exec;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  opSel = 3'd0;
  logic [31:0] rsVal = '0;
  logic [31:0] rtVal = '0;
  logic [15:0] imm = '0;
  logic [4:0]  shamt = '0;
  logic [4:0]  rtIdx = '0;
  logic [4:0]  rdIdx = '0;
  logic [31:0] result;
  logic [4:0]  dstIdx;
  logic        illegalOp;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic [31:0] res;
    logic [4:0]  dst;
    logic        ill;
    string       tag;
  } expItem_t;

  expItem_t sbQ[$];

  always #2.5 clk = ~clk;

  imm_shift_exec i_imm_shift_exec (
    .opSel(opSel), .rsVal(rsVal), .rtVal(rtVal), .imm(imm), .shamt(shamt),
    .rtIdx(rtIdx), .rdIdx(rdIdx), .result(result), .dstIdx(dstIdx),
    .illegalOp(illegalOp)
  );

  function automatic expItem_t model(input logic [2:0] op, input logic [31:0] rs,
                                     input logic [31:0] rt, input logic [15:0] im,
                                     input logic [4:0] sh, input logic [4:0] ti,
                                     input logic [4:0] di);
    expItem_t e;
    logic [31:0] v;
    e.ill = 1'b0;
    e.dst = ti;
    case (op)
      3'd0: e.res = {im, 16'h0000};
      3'd1: e.res = rs & {16'h0000, im};
      3'd2: e.res = rs | {16'h0000, im};
      3'd3: e.res = rs + {{16{im[15]}}, im};
      3'd4: begin
        v = rt;
        for (int k = 0; k < int'(sh); k++) v = {v[30:0], 1'b0};
        e.res = v; e.dst = di;
      end
      3'd5: begin
        v = rt;
        for (int k = 0; k < int'(sh); k++) v = {1'b0, v[31:1]};
        e.res = v; e.dst = di;
      end
      default: begin e.res = '0; e.dst = '0; e.ill = 1'b1; end
    endcase
    return e;
  endfunction

  task automatic drive(input logic [2:0] op, input logic [31:0] rs, input logic [31:0] rt,
                       input logic [15:0] im, input logic [4:0] sh, input logic [4:0] ti,
                       input logic [4:0] di, input string tag);
    expItem_t e;
    @(posedge clk);
    #1;
    opSel = op; rsVal = rs; rtVal = rt; imm = im; shamt = sh; rtIdx = ti; rdIdx = di;
    e = model(op, rs, rt, im, sh, ti, di);
    e.tag = tag;
    sbQ.push_back(e);
  endtask

  task automatic directCheck(input logic [31:0] want, input string tag);
    checks++;
    if (result !== want) begin
      errors++;
      $display("FAIL %s result actual %h expected %h", tag, result, want);
    end
  endtask

  always @(negedge clk) begin
    if (sbQ.size() > 0) begin
      expItem_t e;
      e = sbQ.pop_front();
      checks++;
      if (result !== e.res || dstIdx !== e.dst || illegalOp !== e.ill) begin
        errors++;
        $display("FAIL %s actual res=%h dst=%0d ill=%b expected res=%h dst=%0d ill=%b",
                 e.tag, result, dstIdx, illegalOp, e.res, e.dst, e.ill);
      end
    end
  end

  task automatic buildConst(input logic [31:0] k, input string tag);
    logic [31:0] hi;
    drive(3'd0, 32'hdead_beef, 32'h1234_5678, k[31:16], 5'd3, 5'd8, 5'd9, {tag, " R1 upper"});
    #2;
    hi = result;
    drive(3'd2, hi, 32'h0, k[15:0], 5'd0, 5'd8, 5'd9, {tag, " R3 or"});
    #2;
    directCheck(k, {tag, " R3 constant"});
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    #1;
    checks++;
    if (result !== 32'h0 || dstIdx !== 5'd0 || illegalOp !== 1'b0) begin
      errors++;
      $display("FAIL R1 idle actual %h/%0d/%b expected 0/0/0", result, dstIdx, illegalOp);
    end

    drive(3'd0, 32'hffff_ffff, 32'h0, 16'h7f40, 5'd0, 5'd10, 5'd11, "R1 lui a");
    drive(3'd0, 32'h0, 32'h0, 16'hffff, 5'd0, 5'd31, 5'd1, "R1 lui b");
    drive(3'd1, 32'h7f40_0777, 32'h0, 16'h5555, 5'd0, 5'd11, 5'd2, "R2 andi");
    drive(3'd1, 32'hffff_ffff, 32'h0, 16'h8001, 5'd0, 5'd3, 5'd4, "R2 andi zext");
    drive(3'd2, 32'h1234_0000, 32'h0, 16'hc0de, 5'd0, 5'd5, 5'd6, "R3 ori");
    drive(3'd3, 32'h7f40_0000, 32'h0, 16'h0777, 5'd0, 5'd7, 5'd8, "R4 addi pos");
    drive(3'd3, 32'h0000_0010, 32'h0, 16'hfff0, 5'd0, 5'd7, 5'd8, "R4 addi neg");
    drive(3'd3, 32'hffff_ffff, 32'h0, 16'h0001, 5'd0, 5'd7, 5'd8, "R4 addi wrap");
    drive(3'd3, 32'h7fff_ffff, 32'h0, 16'h0001, 5'd0, 5'd7, 5'd8, "R4 addi ovf");
    drive(3'd4, 32'h0, 32'h8000_0001, 16'h0, 5'd0, 5'd12, 5'd13, "R5 sll 0");
    drive(3'd4, 32'h0, 32'hf000_000f, 16'h0, 5'd4, 5'd12, 5'd13, "R5 sll 4 R7");
    drive(3'd4, 32'h0, 32'hffff_ffff, 16'h0, 5'd31, 5'd12, 5'd13, "R5 sll 31");
    drive(3'd5, 32'h0, 32'h8000_0000, 16'h0, 5'd2, 5'd14, 5'd15, "R6 srl 2");
    drive(3'd5, 32'h0, 32'hffff_ffff, 16'h0, 5'd31, 5'd14, 5'd15, "R6 srl 31 R7");
    drive(3'd5, 32'h0, 32'h1234_5678, 16'h0, 5'd0, 5'd14, 5'd15, "R6 srl 0");
    drive(3'd6, 32'hffff_ffff, 32'hffff_ffff, 16'hffff, 5'd7, 5'd9, 5'd9, "R8 op6");
    drive(3'd7, 32'h1, 32'h1, 16'h1, 5'd1, 5'd9, 5'd9, "R8 op7");
    drive(3'd4, 32'hffff_ffff, 32'h0000_00f0, 16'h1234, 5'd8, 5'd20, 5'd21, "R9 sll rs a");
    drive(3'd4, 32'h0, 32'h0000_00f0, 16'h0, 5'd8, 5'd20, 5'd21, "R9 sll rs b");
    drive(3'd1, 32'h00ff_00ff, 32'hffff_ffff, 16'h0ff0, 5'd0, 5'd22, 5'd23, "R9 andi rt a");
    drive(3'd1, 32'h00ff_00ff, 32'h0, 16'h0ff0, 5'd0, 5'd22, 5'd23, "R9 andi rt b");
    drive(3'd0, 32'h0, 32'h0, 16'h0001, 5'd0, 5'd0, 5'd31, "R7 lui rt");

    buildConst(32'haa55_cc33, "k1");
    buildConst(32'hffff_ffff, "k2");
    buildConst(32'h1001_8008, "k3");
    buildConst(32'h0000_0000, "k4");

    @(posedge clk);
    @(posedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule